// File: doc/BRIEF.md
# Paged Register Map with Shadowed Nonvolatile Storage

This block presents a byte-addressed register space to a host through a simple write strobe, an address and write data, with read data returned combinationally for the current address. The lower half of the address space is always reachable. The upper half is a window whose contents depend on a page-select byte held in the lower half. The populated pages are a shadowed page, a locked page and a control page. The shadowed page is backed by a retained nonvolatile array and has a volatile copy that is read by the host. The locked page is nonvolatile storage that is opened only by a password. The control page holds the shadow-enable bit.

When the shadow-enable bit is clear, a write to the shadowed page starts a timed nonvolatile commit. The `nv_busy` output is high for the whole write time, and every other write is refused until the commit completes. When the bit is set, the same write changes only the volatile copy, with no delay, and the change does not survive a power cycle. Reset models the power cycle. Volatile state clears, but the nonvolatile array is kept. A load sequence then copies the whole shadowed page from the array into the volatile copy before `host_ready` rises.

The controller has three states. ST_LOAD copies one byte per cycle and moves to ST_IDLE after the last byte of the page. ST_IDLE accepts host writes. A write that needs a nonvolatile commit moves it to ST_NVWRITE. ST_NVWRITE counts down the write time, commits the pending byte on its final cycle and returns to ST_IDLE. Reset always enters ST_LOAD.

Top module: `paged_nvmap`

## Requirements
- R1: Addresses 00h to 7Fh reach the lower registers whatever the page select holds. The page-select byte is at 7Fh and can be read back. The password byte is at 7Bh and always reads 0.
- R2: After reset is released, `host_ready` stays low for exactly 128 cycles while the shadowed page is loaded. Writes made during that time have no effect.
- R3: For addresses 80h to FFh, page select 1 maps the shadowed page, 2 the locked page and 4 the control page. Any other page value reads 0, and writes to it are ignored.
- R4: The shadow-enable bit is bit 0 of control-page offset B2h. While it is 1, a write to the shadowed page is readable at once and `nv_busy` stays low.
- R5: While shadow-enable is 0, a write to the shadowed page is readable at once. `nv_busy` is then high for exactly NV_WRITE_CYCLES (default 16) cycles, starting at the write edge.
- R6: While `nv_busy` is high, every host write is refused, to any region.
- R7: After a power cycle, a shadowed byte reads the last value written to it while shadow-enable was 0, and shadow-enable reads 0.
- R8: The locked page can be written, and reads back non-zero data, only while the password byte equals PASSWORD (default 5Ah). Otherwise its writes are ignored without `nv_busy`, and its reads return 0.
- R9: Writes to the locked page are committed with the R5 timing and are kept through a power cycle.
- R10: Just after reset, the lower registers, the page select and the control page read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (models power cycle) |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for host_addr, combinational |
| host_ready | output | 1 | High once the power-up load is done |
| nv_busy | output | 1 | High during a nonvolatile commit |

## Verification
On every cycle the assertions check the following: no commit runs while the load is active, ready never falls without a reset, busy cannot drop while the timer is still counting, and the pending byte holds steady through a commit. They also check that shadow-mode writes and writes to the locked page without the password never start a commit. The bench scenarios cover what the assertions cannot see. These are the exact load and commit lengths, the page mapping, the refusal of writes during busy, and which value each byte returns after a power cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [1:0] {ST_LOAD, ST_IDLE, ST_NVWRITE} pm_state_e;
    typedef enum logic [2:0] {RG_LOWER, RG_SHADOWED, RG_LOCKED, RG_CONTROL, RG_EMPTY} pm_region_e;
endpackage

// File: rtl/pm_decode.sv
module pm_decode
    import pm_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int TSEL_W     = 8,
    parameter int T_SHADOWED = 1,
    parameter int T_LOCKED   = 2,
    parameter int T_CONTROL  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TSEL_W-1:0] tsel,
    output pm_region_e        region,
    output logic [ADDR_W-2:0] offset
);
    always_comb begin
        offset = addr[ADDR_W-2:0];
        if (!addr[ADDR_W-1])                      region = RG_LOWER;
        else if (tsel == TSEL_W'(T_SHADOWED))     region = RG_SHADOWED;
        else if (tsel == TSEL_W'(T_LOCKED))       region = RG_LOCKED;
        else if (tsel == TSEL_W'(T_CONTROL))      region = RG_CONTROL;
        else                                      region = RG_EMPTY;
    end
endmodule

// File: rtl/pm_vol_bank.sv
module pm_vol_bank #(
    parameter int AW     = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pm_nv_store.sv
module pm_nv_store #(
    parameter int AW     = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 2 ** AW;
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/paged_nvmap.sv
module paged_nvmap
    import pm_pkg::*;
#(
    parameter int          ADDR_W          = 8,
    parameter int          DATA_W          = 8,
    parameter int          NV_WRITE_CYCLES = 16,
    parameter int          SEE_OFFSET      = 'h32,
    parameter logic [7:0]  PASSWORD        = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              nv_busy
);
    localparam int OFF_W = ADDR_W - 1;
    localparam int HALF  = 2 ** OFF_W;
    localparam int CNT_W = $clog2(NV_WRITE_CYCLES + 1);
    localparam logic [OFF_W-1:0] TSEL_OFF = OFF_W'(HALF - 1);
    localparam logic [OFF_W-1:0] PW_OFF   = OFF_W'(HALF - 5);
    localparam logic [OFF_W-1:0] SEE_OFF  = OFF_W'(SEE_OFFSET);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(HALF - 1);
    localparam logic [CNT_W-1:0] TIMER_INIT = CNT_W'(NV_WRITE_CYCLES - 1);

    pm_state_e          state_q, state_d;
    logic [OFF_W-1:0]   load_idx_q;
    logic [CNT_W-1:0]   timer_q;
    logic [OFF_W:0]     pend_idx_q;
    logic [DATA_W-1:0]  pend_data_q;
    logic [7:0]         tsel_q;
    logic [DATA_W-1:0]  pw_q;
    logic               see_q;

    pm_region_e         region;
    logic [OFF_W-1:0]   off;
    logic               wr_ok, pw_ok, nv_start, nv_commit;
    logic               lower_we, ctl_we, sh_we;
    logic [OFF_W-1:0]   sh_waddr;
    logic [DATA_W-1:0]  sh_wdata;
    logic [DATA_W-1:0]  lower_rd, ctl_rd, sh_rd, nv_host_rd, nv_load_rd;

    pm_decode #(.ADDR_W(ADDR_W), .TSEL_W(8)) u_dec (
        .addr(host_addr), .tsel(tsel_q), .region(region), .offset(off)
    );

    pm_vol_bank #(.AW(OFF_W), .DATA_W(DATA_W)) u_lower (
        .clk(clk), .rst_n(rst_n), .we(lower_we), .waddr(off), .wdata(host_wdata),
        .raddr(off), .rdata(lower_rd)
    );

    pm_vol_bank #(.AW(OFF_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .waddr(off), .wdata(host_wdata),
        .raddr(off), .rdata(ctl_rd)
    );

    pm_vol_bank #(.AW(OFF_W), .DATA_W(DATA_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .we(sh_we), .waddr(sh_waddr), .wdata(sh_wdata),
        .raddr(off), .rdata(sh_rd)
    );

    pm_nv_store #(.AW(OFF_W + 1), .DATA_W(DATA_W)) u_nv (
        .clk(clk), .we(nv_commit), .waddr(pend_idx_q), .wdata(pend_data_q),
        .raddr_a({1'b1, off}), .rdata_a(nv_host_rd),
        .raddr_b({1'b0, load_idx_q}), .rdata_b(nv_load_rd)
    );

    // write qualification
    always_comb begin
        wr_ok    = host_wr && (state_q == ST_IDLE);
        pw_ok    = (pw_q == PASSWORD);
        lower_we = wr_ok && region == RG_LOWER && off != TSEL_OFF && off != PW_OFF;
        ctl_we   = wr_ok && region == RG_CONTROL && off != SEE_OFF;
        nv_start = wr_ok && ((region == RG_SHADOWED && !see_q) ||
                             (region == RG_LOCKED && pw_ok));
        if (state_q == ST_LOAD) begin
            sh_we    = 1'b1;
            sh_waddr = load_idx_q;
            sh_wdata = nv_load_rd;
        end else begin
            sh_we    = wr_ok && region == RG_SHADOWED;
            sh_waddr = off;
            sh_wdata = host_wdata;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:    if (load_idx_q == LAST_OFF) state_d = ST_IDLE;
            ST_IDLE:    if (nv_start)               state_d = ST_NVWRITE;
            ST_NVWRITE: if (timer_q == '0)          state_d = ST_IDLE;
            default:                                state_d = ST_LOAD;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_LOAD;
            load_idx_q  <= '0;
            timer_q     <= '0;
            pend_idx_q  <= '0;
            pend_data_q <= '0;
            tsel_q      <= '0;
            pw_q        <= '0;
            see_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOAD) load_idx_q <= load_idx_q + 1'b1;
            if (nv_start) begin
                timer_q     <= TIMER_INIT;
                pend_idx_q  <= {region == RG_LOCKED, off};
                pend_data_q <= host_wdata;
            end else if (state_q == ST_NVWRITE && timer_q != '0) begin
                timer_q <= timer_q - 1'b1;
            end
            if (wr_ok && region == RG_LOWER && off == TSEL_OFF) tsel_q <= host_wdata[7:0];
            if (wr_ok && region == RG_LOWER && off == PW_OFF)   pw_q   <= host_wdata;
            if (wr_ok && region == RG_CONTROL && off == SEE_OFF) see_q <= host_wdata[0];
        end
    end

    // outputs
    always_comb begin
        host_ready = (state_q != ST_LOAD);
        nv_busy    = (state_q == ST_NVWRITE);
        nv_commit  = (state_q == ST_NVWRITE) && (timer_q == '0);
        unique case (region)
            RG_LOWER:    host_rdata = (off == TSEL_OFF) ? DATA_W'(tsel_q) :
                                      (off == PW_OFF)   ? '0 : lower_rd;
            RG_SHADOWED: host_rdata = sh_rd;
            RG_LOCKED:   host_rdata = pw_ok ? nv_host_rd : '0;
            RG_CONTROL:  host_rdata = (off == SEE_OFF) ? DATA_W'(see_q) : ctl_rd;
            default:     host_rdata = '0;
        endcase
    end

    // R2: no commit can run while the power-up load is active
    a_r2_no_busy_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |-> !nv_busy);
    // R2: once released, the port stays released until reset
    a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> host_ready);
    // R5: busy cannot end while the write timer is still counting
    a_r5_busy_until_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_busy && timer_q != '0) |=> nv_busy);
    // R6: the pending byte is frozen during a commit
    a_r6_pending_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_busy && $past(nv_busy)) |-> ($stable(pend_idx_q) && $stable(pend_data_q)));
    // R4: a shadow-mode write never starts a commit
    a_r4_shadow_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_ready && !nv_busy && region == RG_SHADOWED && see_q) |=> !nv_busy);
    // R8: the locked page without password never starts a commit
    a_r8_locked_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_ready && !nv_busy && region == RG_LOCKED && !pw_ok) |=> !nv_busy);
endmodule

// File: tb/paged_nvmap_test.sv
`timescale 1ns/1ps
module paged_nvmap_test;
    localparam int NWC = 16;
    localparam logic [7:0] PW = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ready;
    logic       nv_busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    paged_nvmap #(.NV_WRITE_CYCLES(NWC), .PASSWORD(PW)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .nv_busy(nv_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (nv_busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (nv_busy) @(negedge clk);
    endtask

    task automatic power_cycle();
        int low;
        logic [7:0] d;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        host_wr = 1'b1; host_addr = 8'h10; host_wdata = 8'hAA;
        low = 0;
        while (!host_ready && low < 1000) begin
            #1;
            if (!host_ready) low++;
            @(negedge clk);
            host_wr = 1'b0;
        end
        check("R2 load length", low, 128);
        rd(8'h10, d);
        check("R2 write during load ignored", d, 0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        power_cycle();
        rd(8'h7F, d); check("R10 page select", d, 0);
        rd(8'h20, d); check("R10 lower reg", d, 0);
        check("R10 busy low", nv_busy, 0);
    endtask

    task automatic t_lower();
        logic [7:0] d;
        wr(8'h7F, 8'h01);
        wr(8'h20, 8'h33);
        wr(8'h7F, 8'h02);
        rd(8'h20, d); check("R1 lower independent of page", d, 8'h33);
        rd(8'h7F, d); check("R1 page select readback", d, 8'h02);
        wr(8'h7B, 8'h11);
        rd(8'h7B, d); check("R1 password reads zero", d, 0);
        wr(8'h7B, 8'h00);
    endtask

    task automatic t_tables();
        logic [7:0] d;
        wr(8'h7F, 8'h04);
        rd(8'h90, d); check("R10 control page reset", d, 0);
        wr(8'h90, 8'h44);
        wr(8'h7F, 8'h03);
        rd(8'h90, d); check("R3 empty page reads 0", d, 0);
        wr(8'h90, 8'h55);
        check("R3 empty page no busy", nv_busy, 0);
        wr(8'h7F, 8'h04);
        rd(8'h90, d); check("R3 control page kept", d, 8'h44);
        wr(8'h7F, 8'h00);
        rd(8'h90, d); check("R3 page 0 reads 0", d, 0);
    endtask

    task automatic t_nv_write();
        logic [7:0] d;
        int n;
        wr(8'h7F, 8'h01);
        wr(8'h85, 8'h77);
        rd(8'h85, d); check("R5 readable during commit", d, 8'h77);
        busy_len(n);
        check("R5 busy length", n, NWC);
        rd(8'h85, d); check("R5 value after commit", d, 8'h77);
    endtask

    task automatic t_busy_refuse();
        logic [7:0] d;
        wr(8'h10, 8'h01);
        wr(8'h87, 8'h66);
        wait_idle();
        wr(8'h86, 8'h11);
        wr(8'h10, 8'h99);
        wr(8'h87, 8'h22);
        check("R6 still busy", nv_busy, 1);
        wait_idle();
        rd(8'h10, d); check("R6 lower write refused", d, 8'h01);
        wr(8'h7F, 8'h01);
        rd(8'h87, d); check("R6 shadow write refused", d, 8'h66);
    endtask

    task automatic t_shadow();
        logic [7:0] d;
        wr(8'h7F, 8'h04);
        wr(8'hB2, 8'h01);
        rd(8'hB2, d); check("R4 enable readback", d, 1);
        wr(8'h7F, 8'h01);
        wr(8'h85, 8'hEE);
        check("R4 no busy", nv_busy, 0);
        rd(8'h85, d); check("R4 shadow value", d, 8'hEE);
    endtask

    task automatic t_power();
        logic [7:0] d;
        power_cycle();
        wr(8'h7F, 8'h01);
        rd(8'h85, d); check("R7 last nonvolatile value", d, 8'h77);
        rd(8'h86, d); check("R7 second byte", d, 8'h11);
        wr(8'h7F, 8'h04);
        rd(8'hB2, d); check("R7 enable cleared", d, 0);
    endtask

    task automatic t_password();
        logic [7:0] d;
        int n;
        wr(8'h7F, 8'h02);
        wr(8'h7B, PW);
        wr(8'hA0, 8'h34);
        busy_len(n); check("R9 locked commit length", n, NWC);
        rd(8'hA0, d); check("R8 read with password", d, 8'h34);
        wr(8'h7B, 8'h00);
        rd(8'hA0, d); check("R8 read without password", d, 0);
        wr(8'hA0, 8'h56);
        check("R8 no busy without password", nv_busy, 0);
        wr(8'h7B, PW);
        rd(8'hA0, d); check("R8 write without password ignored", d, 8'h34);
        power_cycle();
        wr(8'h7F, 8'h02);
        rd(8'hA0, d); check("R8 locked after power cycle", d, 0);
        wr(8'h7B, PW);
        rd(8'hA0, d); check("R9 retained through power cycle", d, 8'h34);
    endtask

    initial begin
        t_reset();
        t_lower();
        t_tables();
        t_nv_write();
        t_busy_refuse();
        t_shadow();
        t_power();
        t_password();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule